// File: doc/BRIEF.md
# Dual-Strobe Burst Address Generator

This block turns a registered start address into the sequence of word addresses for a four-beat burst into a synchronous burst memory. An access may be opened by either of two active-low strobes. The processor strobe takes priority and is masked by the first chip enable. The controller strobe is not masked by that enable. Once a burst is open, the upper address bits stay at their captured value. Only the two low bits move, through a wraparound counter whose order is linear or interleaved.

An active-low advance input steps the burst by one beat or suspends it. The burst order is taken from a mode input at the moment the burst starts. The design is a control decoder and an address datapath under a thin top. All outputs come straight from registers, so every result appears one clock edge after the inputs that cause it.

Top module: `burst_addr_gen`

## Requirements
- R1: A burst starts at a rising edge when chipSel1N is 0, chipSel2 is 1, chipSel3N is 0 and at least one strobe is 0. After that edge, memAddr equals the addrIn sampled at the edge and addrValid is 1. A strobe sampled while any enable is inactive starts nothing.
- R2: When both strobes are 0 in the same cycle with all enables active, one burst starts from addrIn, exactly as the processor strobe alone would start it.
- R3: While chipSel1N is 1, the processor strobe has no effect. An open burst keeps stepping or holding under advanceN, and its upper bits stay unchanged even if addrIn differs.
- R4: If the controller strobe is 0, or the processor strobe is 0 while chipSel1N is 0, and chipSel2 is 0 or chipSel3N is 1, the cycle is a deselect. After that edge, addrValid is 0.
- R5: With a burst open and no effective strobe, advanceN = 0 moves the low two bits to the next beat. advanceN = 1 holds memAddr unchanged.
- R6: With modeIleave = 1 at the start, beat k (k = 0..3) has low bits equal to start XOR k. A start of 01 gives 01, 00, 11, 10.
- R7: With modeIleave = 0 at the start, beat k has low bits equal to (start + k) mod 4. A start of 10 gives 10, 11, 00, 01.
- R8: After the fourth beat, the next step returns the low bits to the start value. No beat ever changes memAddr bits above bit 1.
- R9: While rstN is 0, addrValid is 0 and memAddr is 0. After reset, advanceN has no effect and addrValid stays 0 until the first qualified start.
- R10: modeIleave is sampled only at a start. Changing it during a burst does not alter that burst's order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addrIn | input | ADDR_W | Start address, sampled at a start |
| procStrobeN | input | 1 | Processor start strobe, active low, masked by chipSel1N |
| ctrlStrobeN | input | 1 | Controller start strobe, active low |
| chipSel1N | input | 1 | Chip enable, active low; also gates the processor strobe |
| chipSel2 | input | 1 | Chip enable, active high |
| chipSel3N | input | 1 | Chip enable, active low |
| advanceN | input | 1 | Step to next beat when low, suspend when high |
| modeIleave | input | 1 | Burst order at start: 1 interleaved, 0 linear |
| memAddr | output | ADDR_W | Current beat address |
| addrValid | output | 1 | An address is being issued |

## Verification
A start, a step, a hold and a deselect are each visible exactly one rising edge after the cycle in which their inputs were presented, because memAddr and addrValid come directly from registers. The bench drives inputs one nanosecond after a rising edge. It waits for the next rising edge and samples one nanosecond later, so each check reads the result of exactly one decoded cycle. Burst sequences are checked beat by beat with one edge between samples, including the fifth step that shows the wrap.

// File: rtl/burst_addr_pkg.sv
`timescale 1ns/1ps
package burst_addr_pkg;
  // Strobes from the decoder to the address datapath
  typedef struct packed {
    logic load;      // capture a new start address
    logic step;      // advance one beat
    logic drop;      // deselect: close the burst
    logic orderIlv;  // order to latch with load
  } seqCtl_t;
endpackage

// File: rtl/burst_addr_ctrl.sv
`timescale 1ns/1ps
module burst_addr_ctrl
  import burst_addr_pkg::*;
(
  input  logic    procStrobeN,
  input  logic    ctrlStrobeN,
  input  logic    chipSel1N,
  input  logic    chipSel2,
  input  logic    chipSel3N,
  input  logic    advanceN,
  input  logic    modeIleave,
  input  logic    burstLive,
  output seqCtl_t ctl
);
  logic chipsOk;
  logic procSeen;
  logic ctrlSeen;
  logic anyStrobe;

  always_comb begin
    chipsOk   = !chipSel1N && chipSel2 && !chipSel3N;
    // processor strobe only counts with the first enable active
    procSeen  = !procStrobeN && !chipSel1N;
    ctrlSeen  = !ctrlStrobeN;
    anyStrobe = procSeen || ctrlSeen;
    ctl.load     = anyStrobe && chipsOk;
    ctl.drop     = anyStrobe && !chipsOk;
    ctl.step     = !anyStrobe && burstLive && !advanceN;
    ctl.orderIlv = modeIleave;
  end
endmodule

// File: rtl/burst_addr_path.sv
`timescale 1ns/1ps
module burst_addr_path
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCtl_t           ctl,
  input  logic [ADDR_W-1:0] addrIn,
  output logic [ADDR_W-1:0] memAddr,
  output logic              burstLive
);
  localparam int UP_W = ADDR_W - BEAT_W;

  logic [UP_W-1:0]   upperQ;
  logic [BEAT_W-1:0] baseQ;
  logic [BEAT_W-1:0] beatQ;
  logic              ilvQ;
  logic              liveQ;
  logic [BEAT_W-1:0] lowBits;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      upperQ <= '0;
      baseQ  <= '0;
      beatQ  <= '0;
      ilvQ   <= 1'b0;
      liveQ  <= 1'b0;
    end else if (ctl.load) begin
      upperQ <= addrIn[ADDR_W-1:BEAT_W];
      baseQ  <= addrIn[BEAT_W-1:0];
      beatQ  <= '0;
      ilvQ   <= ctl.orderIlv;
      liveQ  <= 1'b1;
    end else if (ctl.drop) begin
      liveQ  <= 1'b0;
    end else if (ctl.step) begin
      beatQ  <= beatQ + 1'b1;  // wraps inside BEAT_W bits
    end
  end

  // interleaved: XOR with beat count; linear: modular add
  always_comb begin
    if (ilvQ) lowBits = baseQ ^ beatQ;
    else      lowBits = baseQ + beatQ;
  end

  assign memAddr   = {upperQ, lowBits};
  assign burstLive = liveQ;
endmodule

// File: rtl/burst_addr_gen.sv
`timescale 1ns/1ps
module burst_addr_gen
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              procStrobeN,
  input  logic              ctrlStrobeN,
  input  logic              chipSel1N,
  input  logic              chipSel2,
  input  logic              chipSel3N,
  input  logic              advanceN,
  input  logic              modeIleave,
  output logic [ADDR_W-1:0] memAddr,
  output logic              addrValid
);
  seqCtl_t ctl;
  logic    burstLive;

  burst_addr_ctrl uCtrl (
    .procStrobeN (procStrobeN),
    .ctrlStrobeN (ctrlStrobeN),
    .chipSel1N   (chipSel1N),
    .chipSel2    (chipSel2),
    .chipSel3N   (chipSel3N),
    .advanceN    (advanceN),
    .modeIleave  (modeIleave),
    .burstLive   (burstLive),
    .ctl         (ctl)
  );

  burst_addr_path #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .addrIn    (addrIn),
    .memAddr   (memAddr),
    .burstLive (burstLive)
  );

  assign addrValid = burstLive;
endmodule

// File: rtl/burst_addr_chk.sv
`timescale 1ns/1ps
module burst_addr_chk #(
  parameter int ADDR_W = 18,
  parameter int BEAT_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] addrIn,
  input logic              procStrobeN,
  input logic              ctrlStrobeN,
  input logic              chipSel1N,
  input logic              chipSel2,
  input logic              chipSel3N,
  input logic              advanceN,
  input logic              modeIleave,
  input logic [ADDR_W-1:0] memAddr,
  input logic              addrValid
);
  logic enAll;
  logic quiet;
  assign enAll = !chipSel1N && chipSel2 && !chipSel3N;
  assign quiet = ctrlStrobeN && (procStrobeN || chipSel1N);

  always @(posedge clk) begin
    if (!rstN) begin
      AST_RESET_IDLE: assert (!addrValid && memAddr == '0); // R9
    end
  end

  AST_START_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    (enAll && (!procStrobeN || !ctrlStrobeN)) |=> (addrValid && memAddr == $past(addrIn))); // R1

  AST_DESELECT_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (!enAll && !quiet) |=> !addrValid); // R4

  AST_SUSPEND_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (addrValid && quiet && advanceN) |=> (addrValid && $stable(memAddr))); // R5

  AST_STEP_MOVES: assert property (@(posedge clk) disable iff (!rstN)
    (addrValid && quiet && !advanceN) |=> (memAddr[BEAT_W-1:0] != $past(memAddr[BEAT_W-1:0]))); // R5

  AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rstN)
    (addrValid && quiet) |=> (memAddr[ADDR_W-1:BEAT_W] == $past(memAddr[ADDR_W-1:BEAT_W]))); // R8

  AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rstN)
    (!addrValid && quiet) |=> !addrValid); // R9
endmodule

bind burst_addr_gen burst_addr_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) uChk (
  .clk         (clk),
  .rstN        (rstN),
  .addrIn      (addrIn),
  .procStrobeN (procStrobeN),
  .ctrlStrobeN (ctrlStrobeN),
  .chipSel1N   (chipSel1N),
  .chipSel2    (chipSel2),
  .chipSel3N   (chipSel3N),
  .advanceN    (advanceN),
  .modeIleave  (modeIleave),
  .memAddr     (memAddr),
  .addrValid   (addrValid)
);

// File: tb/burst_addr_gen_test.sv
`timescale 1ns/1ps
module burst_addr_gen_test;
  localparam int AW = 18;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] addrIn = '0;
  logic          procStrobeN = 1'b1;
  logic          ctrlStrobeN = 1'b1;
  logic          chipSel1N = 1'b0;
  logic          chipSel2 = 1'b1;
  logic          chipSel3N = 1'b0;
  logic          advanceN = 1'b1;
  logic          modeIleave = 1'b0;
  logic [AW-1:0] memAddr;
  logic          addrValid;

  int nChecks = 0;
  int nFail = 0;

  always #2 clk = ~clk;  // 250 MHz

  burst_addr_gen uut (
    .clk(clk), .rstN(rstN), .addrIn(addrIn),
    .procStrobeN(procStrobeN), .ctrlStrobeN(ctrlStrobeN),
    .chipSel1N(chipSel1N), .chipSel2(chipSel2), .chipSel3N(chipSel3N),
    .advanceN(advanceN), .modeIleave(modeIleave),
    .memAddr(memAddr), .addrValid(addrValid)
  );

  task automatic chk(input string req, input logic [AW-1:0] expA, input logic expV);
    nChecks++;
    if (addrValid !== expV || (expV && memAddr !== expA)) begin
      nFail++;
      $display("FAIL %s: actual addr=%h valid=%b expected addr=%h valid=%b",
               req, memAddr, addrValid, expA, expV);
    end
  endtask

  // one edge, then sample 1 ns later
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    procStrobeN = 1'b1; ctrlStrobeN = 1'b1;
    chipSel1N = 1'b0; chipSel2 = 1'b1; chipSel3N = 1'b0;
    advanceN = 1'b1;
  endtask

  function automatic logic [1:0] beatLow(input logic [1:0] s, input int k, input logic ilv);
    logic [1:0] kk = k[1:0];
    return ilv ? (s ^ kk) : (s + kk);
  endfunction

  // open a burst via the chosen strobe and check the first beat
  task automatic openBurst(input logic [AW-1:0] a, input logic ilv, input logic useProc, input string req);
    idle();
    addrIn = a; modeIleave = ilv;
    if (useProc) procStrobeN = 1'b0; else ctrlStrobeN = 1'b0;
    tick();
    chk(req, a, 1'b1);
    idle();
  endtask

  task automatic runBeats(input logic [AW-1:0] a, input logic ilv, input string req);
    advanceN = 1'b0;
    for (int k = 1; k <= 4; k++) begin
      tick();
      chk(req, {a[AW-1:2], beatLow(a[1:0], k, ilv)}, 1'b1);
    end
    advanceN = 1'b1;
  endtask

  task automatic tReset();
    rstN = 1'b0;
    tick();
    nChecks++;
    if (addrValid !== 1'b0 || memAddr !== '0) begin
      nFail++;
      $display("FAIL R9: actual addr=%h valid=%b expected addr=0 valid=0", memAddr, addrValid);
    end
    rstN = 1'b1;
    idle();
    advanceN = 1'b0;
    tick(); tick();
    chk("R9 advance before start", '0, 1'b0);
    idle();
  endtask

  task automatic tLinear();
    openBurst(18'h2ABC6, 1'b0, 1'b0, "R1 controller start");
    runBeats(18'h2ABC6, 1'b0, "R7 R8 linear order and wrap");
  endtask

  task automatic tInterleave();
    openBurst(18'h15551, 1'b1, 1'b1, "R1 processor start");
    runBeats(18'h15551, 1'b1, "R6 R8 interleaved order and wrap");
  endtask

  task automatic tSuspend();
    openBurst(18'h00F0C, 1'b0, 1'b0, "R1 start");
    advanceN = 1'b1;
    tick(); chk("R5 suspend", 18'h00F0C, 1'b1);
    tick(); chk("R5 suspend", 18'h00F0C, 1'b1);
    advanceN = 1'b0;
    tick(); chk("R5 step", 18'h00F0D, 1'b1);
    idle();
  endtask

  task automatic tProcIgnored();
    openBurst(18'h3C000, 1'b0, 1'b0, "R1 start");
    chipSel1N = 1'b1; procStrobeN = 1'b0; addrIn = 18'h01233; advanceN = 1'b0;
    tick(); chk("R3 masked strobe, step", 18'h3C001, 1'b1);
    advanceN = 1'b1;
    tick(); chk("R3 masked strobe, hold", 18'h3C001, 1'b1);
    idle();
  endtask

  task automatic tBoth();
    idle();
    addrIn = 18'h2F00B; modeIleave = 1'b0;
    procStrobeN = 1'b0; ctrlStrobeN = 1'b0;
    tick(); chk("R2 both strobes", 18'h2F00B, 1'b1);
    idle();
    advanceN = 1'b0;
    tick(); chk("R2 following beat", 18'h2F008, 1'b1);
    idle();
  endtask

  task automatic tDeselect();
    openBurst(18'h12344, 1'b0, 1'b0, "R1 start");
    ctrlStrobeN = 1'b0; chipSel2 = 1'b0;
    tick(); chk("R4 controller deselect", '0, 1'b0);
    idle(); advanceN = 1'b0;
    tick(); chk("R9 idle after deselect", '0, 1'b0);
    openBurst(18'h12344, 1'b0, 1'b1, "R1 start");
    procStrobeN = 1'b0; chipSel3N = 1'b1;
    tick(); chk("R4 processor deselect", '0, 1'b0);
    idle();
    chipSel1N = 1'b1; ctrlStrobeN = 1'b0; addrIn = 18'h00003;
    tick(); chk("R1 no start with enable off", '0, 1'b0);
    idle();
  endtask

  task automatic tModeChange();
    openBurst(18'h08881, 1'b1, 1'b0, "R1 start");
    modeIleave = 1'b0;
    runBeats(18'h08881, 1'b1, "R10 order fixed at start");
  endtask

  initial begin
    #800000;
    nChecks++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    #1;
    tReset();
    tLinear();
    tInterleave();
    tSuspend();
    tProcIgnored();
    tBoth();
    tDeselect();
    tModeChange();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule